// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits between a simple host request port and a two-bank synchronous DRAM. It turns single-beat reads and writes into the command pulses the memory expects. Each command is one cycle wide and is encoded on chip select, row strobe, column strobe and write enable. After reset it runs the start-up sequence and programs the mode register. It then serves host traffic and inserts an auto refresh at a fixed interval, derived from the clock frequency.

Each bank keeps its last activated row open. A request to the open row of its bank costs only a column command. A request to a different row first closes that bank and then activates the new row. The other bank stays untouched, so traffic that alternates between rows held open in both banks runs without row overhead. The host port follows valid/ready rules. `req_ready` may depend on `req_valid` and the request address. A request is taken only in a cycle where both are high. While `req_valid` is high the host must hold all request fields steady. The block takes no data-path input besides `sd_dq_in`, and read data is returned as a one-cycle `rd_valid` pulse with no back-pressure.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset only NOP is issued for at least PWRUP_CYC cycles. Then come precharge-all (address bit 10 high), two refreshes and the mode set, in that order. `req_ready` stays low until the mode set has been issued.
- R2: The mode set drives the address with burst length code 000 on bits 2..0, the wrap type (1 = interleaved) on bit 3, CAS_LAT on bits 6..4 and the single-write option on bit 9. All other address bits are 0.
- R3: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, MODE SET=0000. No other code appears, and during reset the pins show NOP.
- R4: A request to the open row of its bank issues only a column command. That command carries the bank on address bit 11, the column on the low COLW bits and bit 10 low.
- R5: A request to a bank whose open row differs first issues a precharge of that bank alone (bit 10 low, bit 11 = bank). The new row is activated afterwards.
- R6: A request to a closed bank issues ACTIVE with the row on bits 10..0 and the bank on bit 11.
- R7: Commands on the pins keep these spacings: ACTIVE to a column command in that bank at least T_RCD cycles; precharge to ACTIVE or REFRESH at least T_RP; REFRESH to any non-NOP command at least T_RFC; mode set to any non-NOP command at least T_MRD.
- R8: Once requests are served, successive refreshes are at most REFI_CYC + T_RP + T_RFC + T_RCD + 4 cycles apart. A refresh is only issued while both banks are closed, and a precharge-all is issued first if needed.
- R9: While a refresh is due, no request is accepted.
- R10: A request is accepted only in a cycle with both `req_valid` and `req_ready` high. Requests are served in order, and a read returns the value of the most recent earlier unmasked write to the same bank, row and column.
- R11: `sd_dq_oe` is high exactly in the cycles where WRITE is on the pins. In those cycles `sd_dq_out` is the write data, and `sd_dqm` is the host mask (1 = masked).
- R12: `rd_valid` pulses exactly CAS_LAT+1 cycles after a READ is on the pins. `rd_data` then equals `sd_dq_in` from the cycle before.
- R13: Accesses that alternate between rows already open in the two banks issue no ACTIVE and no precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank select |
| req_row | input | ROWW | Row address |
| req_col | input | COLW | Column address |
| req_wdata | input | DW | Write data |
| req_wmask | input | DMW | Write mask, 1 = lane not written |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data |
| sd_cs_n | output | 1 | Chip select strobe |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable strobe |
| sd_addr | output | ROWW+1 | Multiplexed address, top bit = bank |
| sd_dqm | output | DMW | Data mask |
| sd_dq_out | output | DW | Data toward memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DW | Data from memory |

## Verification
A refresh can fall due in the same cycle that a host request would hit an open row. In that case refresh has to win. The bench provokes this by keeping the request port saturated with random hits and misses over several refresh intervals. A memory model on the pins then judges the result. It checks that each refresh is preceded by a closing of every bank, that refresh gaps stay within the R8 bound, and that no column command lands inside a precharge or refresh window. Read-back of every address shows that no request was lost or reordered around the inserted refreshes.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    PH_PWR, PH_IREF1, PH_IREF2, PH_IMRS, PH_RUN
  } ctrl_phase_e;
endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= W'(RST_VAL);
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int PERIOD = 3906
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic due
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = run && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due   <= 1'b0;
    end else begin
      if (run) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)     due <= 1'b1;
      else if (ack) due <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
  parameter int NBANK = 2,
  parameter int ROWW  = 11,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW-1:0]   look_bank,
  input  logic [ROWW-1:0] look_row,
  output logic            look_open,
  output logic            look_hit,
  output logic            any_open,
  input  logic            act_en,
  input  logic [BW-1:0]   act_bank,
  input  logic [ROWW-1:0] act_row,
  input  logic            pre_en,
  input  logic            pre_all,
  input  logic [BW-1:0]   pre_bank
);
  logic [NBANK-1:0] open_q;
  logic [ROWW-1:0]  row_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (act_en && act_bank == BW'(b)) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= act_row;
      end else if (pre_en && (pre_all || pre_bank == BW'(b))) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign look_open = open_q[look_bank];
  assign look_hit  = look_open && (row_q[look_bank] == look_row);
  assign any_open  = |open_q;
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int CLK_MHZ         = 250,
  parameter int REFI_NS         = 15625,
  parameter int PWRUP_CYC       = 25000,
  parameter int T_RCD           = 3,
  parameter int T_RP            = 3,
  parameter int T_RFC           = 9,
  parameter int T_MRD           = 2,
  parameter int CAS_LAT         = 3,
  parameter int WRAP_INTERLEAVE = 0,
  parameter int WRITE_SINGLE    = 0,
  parameter int DW              = 8,
  parameter int DMW             = 1,
  parameter int COLW            = 9,
  parameter int ROWW            = 11,
  localparam int ADRW           = ROWW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_bank,
  input  logic [ROWW-1:0] req_row,
  input  logic [COLW-1:0] req_col,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DMW-1:0]  req_wmask,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            sd_cs_n,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic [ADRW-1:0] sd_addr,
  output logic [DMW-1:0]  sd_dqm,
  output logic [DW-1:0]   sd_dq_out,
  output logic            sd_dq_oe,
  input  logic [DW-1:0]   sd_dq_in
);
  localparam int REFI_CYC = CLK_MHZ * REFI_NS / 1000;
  localparam int TW       = $clog2(PWRUP_CYC + T_RFC + T_RCD + T_RP + T_MRD + 1);
  localparam int AP_BIT   = ROWW - 1;
  localparam int BANK_BIT = ADRW - 1;
  localparam logic [ADRW-1:0] MODE_WORD =
    ADRW'((WRITE_SINGLE << 9) | (CAS_LAT << 4) | (WRAP_INTERLEAVE << 3));

  ctrl_phase_e     phase_q, phase_d;
  sdram_cmd_e      cmd_q, cmd_d;
  logic [ADRW-1:0] addr_q, addr_d;
  logic [DMW-1:0]  dqm_q, dqm_d;
  logic [DW-1:0]   dq_q, dq_d, rd_data_q;
  logic            oe_q, oe_d;
  logic [CAS_LAT:0] rd_pipe_q;

  logic          t_load, t_idle;
  logic [TW-1:0] t_val;
  logic          ref_due, ref_ack, run_w;
  logic          look_open, look_hit, any_open;
  logic          act_en, pre_en, pre_all;

  assign run_w = (phase_q == PH_RUN);

  sdram_gap_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_gap (
    .clk, .rst_n, .load(t_load), .load_val(t_val), .idle(t_idle));

  sdram_refresh_timer #(.PERIOD(REFI_CYC)) u_refi (
    .clk, .rst_n, .run(run_w), .ack(ref_ack), .due(ref_due));

  sdram_row_tracker #(.NBANK(2), .ROWW(ROWW)) u_rows (
    .clk, .rst_n,
    .look_bank(req_bank), .look_row(req_row),
    .look_open, .look_hit, .any_open,
    .act_en, .act_bank(req_bank), .act_row(req_row),
    .pre_en, .pre_all, .pre_bank(req_bank));

  always_comb begin
    phase_d   = phase_q;
    cmd_d     = CMD_NOP;
    addr_d    = '0;
    dqm_d     = '0;
    dq_d      = '0;
    oe_d      = 1'b0;
    t_load    = 1'b0;
    t_val     = '0;
    act_en    = 1'b0;
    pre_en    = 1'b0;
    pre_all   = 1'b0;
    ref_ack   = 1'b0;
    req_ready = 1'b0;
    if (t_idle) begin
      unique case (phase_q)
        PH_PWR: begin
          cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; pre_en = 1'b1; pre_all = 1'b1;
          t_load = 1'b1; t_val = TW'(T_RP - 1); phase_d = PH_IREF1;
        end
        PH_IREF1, PH_IREF2: begin
          cmd_d = CMD_REF; t_load = 1'b1; t_val = TW'(T_RFC - 1);
          phase_d = (phase_q == PH_IREF1) ? PH_IREF2 : PH_IMRS;
        end
        PH_IMRS: begin
          cmd_d = CMD_MRS; addr_d = MODE_WORD;
          t_load = 1'b1; t_val = TW'(T_MRD - 1); phase_d = PH_RUN;
        end
        default: begin
          if (ref_due) begin
            t_load = 1'b1;
            if (any_open) begin
              cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; pre_en = 1'b1; pre_all = 1'b1;
              t_val = TW'(T_RP - 1);
            end else begin
              cmd_d = CMD_REF; ref_ack = 1'b1; t_val = TW'(T_RFC - 1);
            end
          end else if (req_valid) begin
            addr_d[BANK_BIT] = req_bank;
            t_load = 1'b1;
            if (look_hit) begin
              req_ready = 1'b1;
              addr_d[COLW-1:0] = req_col;
              t_val = '0;
              if (req_write) begin
                cmd_d = CMD_WR; oe_d = 1'b1; dq_d = req_wdata; dqm_d = req_wmask;
              end else begin
                cmd_d = CMD_RD;
              end
            end else if (look_open) begin
              cmd_d = CMD_PRE; pre_en = 1'b1; t_val = TW'(T_RP - 1);
            end else begin
              cmd_d = CMD_ACT; act_en = 1'b1; addr_d[ROWW-1:0] = req_row;
              t_val = TW'(T_RCD - 1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_PWR;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      dqm_q     <= '0;
      dq_q      <= '0;
      oe_q      <= 1'b0;
      rd_pipe_q <= '0;
      rd_data_q <= '0;
    end else begin
      phase_q   <= phase_d;
      cmd_q     <= cmd_d;
      addr_q    <= addr_d;
      dqm_q     <= dqm_d;
      dq_q      <= dq_d;
      oe_q      <= oe_d;
      rd_pipe_q <= {rd_pipe_q[CAS_LAT-1:0], cmd_q == CMD_RD};
      rd_data_q <= sd_dq_in;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign rd_valid  = rd_pipe_q[CAS_LAT];
  assign rd_data   = rd_data_q;
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       addr_ap,
  input logic       dq_oe,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       ref_due,
  input logic       run
);
  // R9
  ref_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due |-> !req_ready);
  // R1
  init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !req_ready);
  // R4
  col_no_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> !addr_ap);
  // R11
  oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> cmd == 4'b0100);
  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd == 4'b0101, CAS_LAT + 1));
  // R3
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111});
  if (T_RCD > 1) begin : g_rcd
    // R7
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 4'b0011 |=> cmd == 4'b0111);
  end
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.CAS_LAT(CAS_LAT), .T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .addr_ap(sd_addr[ROWW-1]), .dq_oe(sd_dq_oe), .req_ready(req_ready),
  .rd_valid(rd_valid), .ref_due(ref_due), .run(run_w));

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;
  localparam int PWR = 500, RCD = 3, RP = 3, RFC = 9, MRD = 2, CL = 3;
  localparam int WRAP = 1, WSGL = 1, DW = 8, COLW = 9, ROWW = 11;
  localparam int REFI = 250 * 15625 / 1000;
  localparam int REF_BOUND = REFI + RP + RFC + RCD + 4;
  localparam logic [11:0] MODE_EXP = 12'(WSGL << 9 | CL << 4 | WRAP << 3);

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_bank = 0;
  logic [ROWW-1:0] req_row = '0;
  logic [COLW-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0, sd_dq_in = '0;
  logic [0:0] req_wmask = '0;
  logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DW-1:0] rd_data, sd_dq_out;
  logic [11:0] sd_addr;
  logic [0:0] sd_dqm;

  sdram_cmd_ctrl #(.PWRUP_CYC(PWR), .T_RCD(RCD), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD),
    .CAS_LAT(CL), .WRAP_INTERLEAVE(WRAP), .WRITE_SINGLE(WSGL)) u_dut (.*);

  int vectors = 0, errors = 0, cyc = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin errors++; $display("FAIL %s actual %0h expected %0h", req, act, exp); end
  endtask

  logic [DW-1:0] sd_mem [int];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] pend [0:CL];
  logic [DW-1:0] exp_q [$];
  int rd_cyc_q [$];
  bit open_m [2];
  logic [ROWW-1:0] row_m [2];
  int last_act [2] = '{-1000, -1000}, last_pre [2] = '{-1000, -1000};
  int last_ref = -1000, last_mrs = -1000, ref_base = 0, init_idx = 0;
  int act_cnt = 0, pre1_cnt = 0, run_refs = 0;

  function automatic int keyof(logic b, logic [ROWW-1:0] r, logic [COLW-1:0] c);
    return int'({b, r, c});
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [3:0] cmd;
    logic b;
    int k;
    cyc++;
    for (int i = 0; i < CL; i++) pend[i] = pend[i+1];
    pend[CL] = '0;
    sd_dq_in = pend[0];
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = sd_addr[11];
    if (rd_valid) begin
      chk(exp_q.size() > 0, "R12 unexpected rd_valid", 1, 0);
      if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        int rc;
        e = exp_q.pop_front(); rc = rd_cyc_q.pop_front();
        chk(rd_data == e, "R10 read data", rd_data, e);
        chk(cyc == rc + CL + 1, "R12 read latency", cyc - rc, CL + 1);
      end
    end
    chk(sd_dq_oe == (cmd == 4'b0100), "R11 dq_oe", sd_dq_oe, cmd == 4'b0100);
    if (cmd != 4'b0111 && cmd != 4'b0000)
      chk(cyc - last_mrs >= MRD, "R7 mode gap", cyc - last_mrs, MRD);
    if (cmd != 4'b0111)
      chk(cyc - last_ref >= RFC, "R7 refresh gap", cyc - last_ref, RFC);
    case (cmd)
      4'b0111: ;
      4'b0010: begin
        if (init_idx == 0) begin
          chk(sd_addr[10] && cyc >= PWR, "R1 first precharge", cyc, PWR);
          init_idx = 1;
        end
        if (sd_addr[10]) begin
          open_m = '{0, 0}; last_pre = '{cyc, cyc};
        end else begin
          chk(open_m[b], "R5 precharge of open bank", open_m[b], 1);
          open_m[b] = 0; last_pre[b] = cyc; pre1_cnt++;
        end
      end
      4'b0001: begin
        chk(!open_m[0] && !open_m[1], "R8 banks closed at refresh", {open_m[0], open_m[1]}, 0);
        chk(cyc - last_pre[0] >= RP && cyc - last_pre[1] >= RP, "R7 tRP before refresh", cyc, 0);
        if (init_idx == 1 || init_idx == 2) init_idx++;
        else if (init_idx == 4) begin
          chk(cyc - ref_base <= REF_BOUND, "R8 refresh interval", cyc - ref_base, REF_BOUND);
          ref_base = cyc; run_refs++;
        end else chk(0, "R1 init order", init_idx, 3);
        last_ref = cyc;
      end
      4'b0000: begin
        chk(init_idx == 3, "R1 mode set order", init_idx, 3);
        chk(sd_addr == MODE_EXP, "R2 mode word", sd_addr, MODE_EXP);
        init_idx = 4; last_mrs = cyc; ref_base = cyc;
      end
      4'b0011: begin
        chk(init_idx == 4, "R1 activate before init", init_idx, 4);
        chk(!open_m[b], "R6 activate closed bank", open_m[b], 0);
        chk(cyc - last_pre[b] >= RP, "R7 tRP", cyc - last_pre[b], RP);
        open_m[b] = 1; row_m[b] = sd_addr[10:0]; last_act[b] = cyc; act_cnt++;
      end
      4'b0100, 4'b0101: begin
        chk(open_m[b], "R4 column to open bank", open_m[b], 1);
        chk(!sd_addr[10], "R4 A10 low", sd_addr[10], 0);
        chk(cyc - last_act[b] >= RCD, "R7 tRCD", cyc - last_act[b], RCD);
        k = keyof(b, row_m[b], sd_addr[COLW-1:0]);
        if (cmd == 4'b0100) begin
          if (!sd_dqm[0]) sd_mem[k] = sd_dq_out;
        end else begin
          pend[CL] = sd_mem.exists(k) ? sd_mem[k] : '0;
          rd_cyc_q.push_back(cyc);
        end
      end
      default: chk(0, "R3 illegal command", cmd, 4'b0111);
    endcase
  end

  task automatic send(bit w, bit b, logic [ROWW-1:0] r, logic [COLW-1:0] c,
                      logic [DW-1:0] d, bit m);
    int k;
    req_valid = 1; req_write = w; req_bank = b; req_row = r; req_col = c;
    req_wdata = d; req_wmask = m;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    chk(init_idx == 4, "R10 acceptance after init", init_idx, 4);
    k = keyof(b, r, c);
    if (w) begin
      if (!m) shadow[k] = d;
    end else exp_q.push_back(shadow.exists(k) ? shadow[k] : '0);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int a0, p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R3 reset NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(!req_ready && !rd_valid && !sd_dq_oe, "R1 reset outputs quiet", req_ready, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: request waiting from the start must not be taken early
    send(1, 0, 11'd5, 9'd1, 8'hA5, 0);
    send(1, 1, 11'd9, 9'd2, 8'h3C, 0);
    a0 = act_cnt; p0 = pre1_cnt;
    for (int i = 0; i < 8; i++) send(0, i[0], i[0] ? 11'd9 : 11'd5, i[0] ? 9'd2 : 9'd1, 0, 0);
    chk(act_cnt == a0 && pre1_cnt == p0, "R13 interleave without row overhead",
        act_cnt - a0 + pre1_cnt - p0, 0);
    p0 = pre1_cnt;
    send(0, 0, 11'd6, 9'd1, 0, 0);
    chk(pre1_cnt == p0 + 1, "R5 row miss precharges bank", pre1_cnt - p0, 1);
    send(1, 0, 11'd6, 9'd1, 8'h77, 1);
    send(0, 0, 11'd6, 9'd1, 0, 0);   // masked write leaves 0 (R11)
    send(0, 0, 11'd5, 9'd1, 0, 0);   // reopened row keeps A5 (R10)
    for (int i = 0; i < 1500; i++)
      send($urandom % 2, $urandom % 2, 11'($urandom % 4), 9'($urandom % 8),
           8'($urandom), ($urandom % 4) == 0);
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 0);
    chk(run_refs >= 2, "R8 refreshes during traffic", run_refs, 2);
    chk(cyc - ref_base <= REF_BOUND, "R8 final interval", cyc - ref_base, REF_BOUND);
    finish_run();
  end
endmodule